// File: doc/BRIEF.md
# Platform external interrupt controller

This block collects level interrupt lines from up to 31 peripheral sources and reduces them to one interrupt request toward a processor. Every source owns an enable bit, a 3-bit urgency value and a pending bit. One threshold register filters out sources that are not urgent enough. On each cycle the controller picks the best eligible pending source: the highest urgency first, then the lowest ID on a tie. It registers that source's ID and raises the request output while the ID is not zero.

Software reaches every register through a plain synchronous word bus. A read of the claim/complete register returns the chosen ID. When the handler is done, software writes that same ID back to the same address. This clears the source's pending bit, and the next best source moves up. ID 0 means "nothing to serve".

Top module: `extirq_ctrl`

## Requirements
- R1: After reset every pending bit, enable bit, urgency value and the threshold read 0. The claim register reads 0 and `irq_o` is low.
- R2: A high level on source line n sets bit n of the pending word (address 0x100) at the next clock edge. The bit stays set after the line drops. Bit 0 always reads 0.
- R3: Bit n of the enable word (address 0x200) belongs to source n. A disabled source still records pending but is never chosen.
- R4: The urgency of source n lives in bits 2:0 of the word at address 4·n. A source with urgency 0 is never chosen.
- R5: Among eligible pending sources, the one with the largest urgency is chosen. Ties go to the lowest ID.
- R6: A source is eligible only when its urgency is strictly above the threshold (bits 2:0 at 0x300). A threshold of 7 blocks every source.
- R7: A read of 0x304 returns the ID of the chosen source, or 0 when none is eligible. Read data appears one cycle after `bus_rd` and holds until the next read. Addresses with bits 1:0 non-zero are ignored.
- R8: A write to 0x304 whose data equals the held non-zero ID clears that source's pending bit at that edge. The next best ID is loaded one edge later.
- R9: A write to 0x304 whose data differs from the held ID clears no pending bit and leaves the held ID unchanged.
- R10: `irq_o` is a register. It goes high one edge after a pending bit becomes eligible and low one edge after no source is eligible.
- R11: When a completion hits a source whose line is still high, the clear wins at that edge. The source pends again at the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-flop synchronizer |
| src_irq | input | NUM_SRC | Level interrupt lines; bit n is source n (n = 1..NUM_SRC) |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A completion write and a fresh request from the same source can hit the same clock edge. The bench provokes this by holding a source line high while software writes its ID to the claim/complete register. It then reads the pending word twice in a row. The first read must show the bit cleared and `irq_o` low for one cycle. The second read must show the bit set again, with the ID back in the claim register.

// File: rtl/extirq_pkg.sv
package extirq_pkg;
  localparam int PRIO_W = 3;
  typedef logic [PRIO_W-1:0] prio_t;

  localparam logic [1:0] RGN_PRIO = 2'b00;
  localparam logic [1:0] RGN_PEND = 2'b01;
  localparam logic [1:0] RGN_EN   = 2'b10;
  localparam logic [1:0] RGN_CTL  = 2'b11;

  localparam logic [5:0] CTL_THR  = 6'd0;
  localparam logic [5:0] CTL_CLM  = 6'd1;
endpackage

// File: rtl/extirq_src.sv
module extirq_src
  import extirq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_ni,
  input  logic  line_i,
  input  logic  en_wr_i,
  input  logic  en_bit_i,
  input  logic  prio_wr_i,
  input  prio_t prio_wdata_i,
  input  logic  clr_i,
  output logic  pend_o,
  output logic  en_o,
  output prio_t prio_o
);
  logic  pend_q, pend_d;
  logic  en_q, en_d;
  prio_t prio_q, prio_d;

  always_comb begin
    pend_d = clr_i ? 1'b0 : (pend_q | line_i);
    en_d   = en_wr_i ? en_bit_i : en_q;
    prio_d = prio_wr_i ? prio_wdata_i : prio_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      en_q   <= 1'b0;
      prio_q <= '0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      prio_q <= prio_d;
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign prio_o = prio_q;

  AST_PEND_SET: assert property (@(posedge clk) disable iff (!rst_ni)
    (line_i && !clr_i) |=> pend_q); // R2
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_ni)
    clr_i |=> !pend_q); // R11
endmodule

// File: rtl/extirq_arbiter.sv
module extirq_arbiter
  import extirq_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int ID_W    = 5
) (
  input  logic                      clk,
  input  logic                      rst_ni,
  input  logic [NUM_SRC:1]          pend_i,
  input  logic [NUM_SRC:1]          en_i,
  input  logic [NUM_SRC*PRIO_W-1:0] prio_i,
  input  prio_t                     thr_i,
  output logic [ID_W-1:0]           best_id_o,
  output prio_t                     best_prio_o
);
  prio_t cand;

  // Scan from the highest ID down; ">=" lets a lower ID take a tie.
  always_comb begin
    best_id_o   = '0;
    best_prio_o = '0;
    cand        = '0;
    for (int i = NUM_SRC; i >= 1; i--) begin
      cand = prio_i[(i-1)*PRIO_W +: PRIO_W];
      if (pend_i[i] && en_i[i] && (cand > thr_i) && (cand >= best_prio_o)) begin
        best_id_o   = ID_W'(i);
        best_prio_o = cand;
      end
    end
  end

  AST_WIN_ABOVE_THR: assert property (@(posedge clk) disable iff (!rst_ni)
    (best_id_o != '0) |-> (best_prio_o > thr_i)); // R6
  AST_WIN_ENABLED: assert property (@(posedge clk) disable iff (!rst_ni)
    (best_id_o != '0) |-> (pend_i[best_id_o] && en_i[best_id_o])); // R3
endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
  import extirq_pkg::*;
#(
  parameter int NUM_SRC = 31,
  parameter int ADDR_W  = 10,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   src_irq,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_wr,
  input  logic               bus_rd,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic               irq_o
);
  localparam int ID_W = $clog2(NUM_SRC + 1);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_q;
  logic       rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  // address decode
  logic [1:0] rgn;
  logic [5:0] word;
  logic       aligned;
  logic       thr_wr, cmp_wr, en_wr, cmp_hit;
  assign rgn     = bus_addr[9:8];
  assign word    = bus_addr[7:2];
  assign aligned = (bus_addr[1:0] == 2'b00);
  assign thr_wr  = bus_wr && aligned && (rgn == RGN_CTL) && (word == CTL_THR);
  assign cmp_wr  = bus_wr && aligned && (rgn == RGN_CTL) && (word == CTL_CLM);
  assign en_wr   = bus_wr && aligned && (rgn == RGN_EN);

  logic [ID_W-1:0] held_id_q, held_id_d;
  assign cmp_hit = cmp_wr && (held_id_q != '0) && (bus_wdata == DATA_W'(held_id_q));

  // per-source state
  logic [NUM_SRC:1]          pend_vec, en_vec;
  logic [NUM_SRC*PRIO_W-1:0] prio_flat;

  for (genvar g = 1; g <= NUM_SRC; g++) begin : g_src
    logic prio_wr, clr;
    assign prio_wr = bus_wr && aligned && (rgn == RGN_PRIO) && (word == 6'(g));
    assign clr     = cmp_hit && (held_id_q == ID_W'(g));
    extirq_src u_src (
      .clk          (clk),
      .rst_ni       (rst_i_n),
      .line_i       (src_irq[g]),
      .en_wr_i      (en_wr),
      .en_bit_i     (bus_wdata[g]),
      .prio_wr_i    (prio_wr),
      .prio_wdata_i (bus_wdata[PRIO_W-1:0]),
      .clr_i        (clr),
      .pend_o       (pend_vec[g]),
      .en_o         (en_vec[g]),
      .prio_o       (prio_flat[(g-1)*PRIO_W +: PRIO_W])
    );
  end

  // arbitration
  prio_t           thr_q, thr_d;
  logic [ID_W-1:0] best_id;
  prio_t           best_prio;

  extirq_arbiter #(.NUM_SRC(NUM_SRC), .ID_W(ID_W)) u_arb (
    .clk         (clk),
    .rst_ni      (rst_i_n),
    .pend_i      (pend_vec),
    .en_i        (en_vec),
    .prio_i      (prio_flat),
    .thr_i       (thr_q),
    .best_id_o   (best_id),
    .best_prio_o (best_prio)
  );

  // next state
  logic              irq_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  prio_t             rd_prio;

  always_comb begin
    thr_d     = thr_wr ? bus_wdata[PRIO_W-1:0] : thr_q;
    held_id_d = best_id;
    irq_d     = (best_id != '0);

    rd_prio = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (word == 6'(i)) rd_prio = prio_flat[(i-1)*PRIO_W +: PRIO_W];
    end

    rdata_d = '0;
    if (aligned) begin
      unique case (rgn)
        RGN_PRIO: rdata_d = DATA_W'(rd_prio);
        RGN_PEND: rdata_d = DATA_W'({pend_vec, 1'b0});
        RGN_EN:   rdata_d = DATA_W'({en_vec, 1'b0});
        RGN_CTL: begin
          if (word == CTL_THR)      rdata_d = DATA_W'(thr_q);
          else if (word == CTL_CLM) rdata_d = DATA_W'(held_id_q);
        end
        default:  rdata_d = '0;
      endcase
    end
  end

  // registers
  logic irq_q;
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      thr_q     <= '0;
      held_id_q <= '0;
      irq_q     <= 1'b0;
      rdata_q   <= '0;
    end else begin
      thr_q     <= thr_d;
      held_id_q <= held_id_d;
      irq_q     <= irq_d;
      if (bus_rd) rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq_o     = irq_q;

  AST_THR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (thr_q == 3'd7) |=> !irq_o); // R6
  AST_MISMATCH_KEEPS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (cmp_wr && (bus_wdata != DATA_W'(held_id_q))) |=> (($past(pend_vec) & ~pend_vec) == '0)); // R9
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_i_n)
    (best_id != '0) |=> irq_o); // R10
  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_i_n)
    (best_id == '0) |=> (!irq_o && (held_id_q == '0))); // R7
endmodule

// File: tb/extirq_ctrl_bench.sv
module extirq_ctrl_bench;
  localparam int NUM_SRC = 31;
  localparam logic [9:0] A_PEND = 10'h100;
  localparam logic [9:0] A_EN   = 10'h200;
  localparam logic [9:0] A_THR  = 10'h300;
  localparam logic [9:0] A_CLM  = 10'h304;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC:1]   src_irq = '0;
  logic [9:0]         bus_addr = '0;
  logic               bus_wr = 1'b0;
  logic               bus_rd = 1'b0;
  logic [31:0]        bus_wdata = '0;
  logic [31:0]        bus_rdata;
  logic               irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #5 clk = ~clk;

  extirq_ctrl #(.NUM_SRC(NUM_SRC)) u_extirq_ctrl (
    .clk(clk), .rst_n(rst_n), .src_irq(src_irq),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o)
  );

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [9:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  // driver side: issue a read and queue its expected value
  task automatic rd(input logic [9:0] a, input logic [31:0] exp, input string tag);
    exp_t it;
    it.exp = exp; it.tag = tag;
    sb_q.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic pulse(input logic [NUM_SRC:1] lines);
    src_irq = lines;
    @(negedge clk);
    src_irq = '0;
  endtask

  // monitor: pop the expected item once the read data is out
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        exp_t it;
        @(negedge clk);
        it = sb_q.pop_front();
        chk(bus_rdata, it.exp, it.tag);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(4);

    // R1 reset state
    chk({31'd0, irq_o}, 32'd0, "R1 irq after reset");
    rd(A_PEND, 32'd0, "R1 pending");
    rd(A_EN, 32'd0, "R1 enable");
    rd(A_THR, 32'd0, "R1 threshold");
    rd(A_CLM, 32'd0, "R1 claim");
    rd(10'h014, 32'd0, "R1 urgency of 5");

    // R2 pending captured, sticky after line drops
    pulse((31'd1 << 2) | (31'd1 << 6));
    tick(3);
    rd(A_PEND, 32'h88, "R2 pending sticky");

    // R3 disabled sources not chosen while still pending
    wr(10'h00C, 32'd2);
    wr(10'h01C, 32'd5);
    tick(2);
    rd(10'h01C, 32'd5, "R4 urgency readback");
    rd(A_CLM, 32'd0, "R3 disabled not chosen");
    chk({31'd0, irq_o}, 32'd0, "R3 irq low while disabled");
    wr(A_EN, 32'h88);
    tick(2);
    rd(A_CLM, 32'd7, "R5 higher urgency wins");
    chk({31'd0, irq_o}, 32'd1, "R10 irq high");

    // R5 tie goes to lower ID
    wr(10'h01C, 32'd2);
    tick(2);
    rd(A_CLM, 32'd3, "R5 tie lowest ID");

    // R4 urgency 0 never chosen
    wr(10'h00C, 32'd0);
    tick(2);
    rd(A_CLM, 32'd7, "R4 urgency zero skipped");

    // R6 threshold
    wr(A_THR, 32'd2);
    tick(2);
    rd(A_CLM, 32'd0, "R6 equal to threshold blocked");
    chk({31'd0, irq_o}, 32'd0, "R6 irq low under threshold");
    wr(A_THR, 32'd1);
    tick(2);
    rd(A_CLM, 32'd7, "R6 above threshold passes");
    wr(10'h00C, 32'd7);
    wr(A_THR, 32'd7);
    tick(2);
    rd(A_CLM, 32'd0, "R6 threshold 7 blocks all");
    wr(A_THR, 32'd0);
    tick(2);
    rd(A_CLM, 32'd3, "R7 claim returns best");

    // R9 mismatched completion
    wr(A_CLM, 32'd7);
    tick(2);
    rd(A_PEND, 32'h88, "R9 mismatch keeps pending");
    rd(A_CLM, 32'd3, "R9 mismatch keeps ID");

    // R8 matching completion
    wr(A_CLM, 32'd3);
    tick(2);
    rd(A_PEND, 32'h80, "R8 complete clears bit");
    rd(A_CLM, 32'd7, "R8 next best loaded");
    wr(A_CLM, 32'd7);
    tick(2);
    rd(A_PEND, 32'd0, "R8 all cleared");
    rd(A_CLM, 32'd0, "R7 nothing eligible");
    chk({31'd0, irq_o}, 32'd0, "R10 irq drops");

    // R11 completion while the line is still high
    wr(10'h014, 32'd4);
    wr(A_EN, 32'hA8);
    src_irq = 31'd1 << 4;
    tick(2);
    rd(A_CLM, 32'd5, "R11 source 5 held");
    wr(A_CLM, 32'd5);
    rd(A_PEND, 32'd0, "R11 clear wins at the edge");
    chk({31'd0, irq_o}, 32'd0, "R11 irq gap");
    rd(A_PEND, 32'h20, "R11 re-pends next edge");
    chk({31'd0, irq_o}, 32'd1, "R11 irq back");
    src_irq = '0;
    tick(1);
    wr(A_CLM, 32'd5);
    tick(2);
    rd(A_PEND, 32'd0, "R8 clear after line drop");

    // R7 misaligned address ignored
    wr(10'h302, 32'd7);
    tick(1);
    rd(A_THR, 32'd0, "R7 misaligned write ignored");

    // boundary IDs 1 and 31
    wr(10'h004, 32'd1);
    wr(10'h07C, 32'd6);
    wr(A_EN, 32'hFFFF_FFFF);
    pulse((31'd1 << 0) | (31'd1 << 30));
    tick(2);
    rd(A_CLM, 32'd31, "R5 top ID wins");
    wr(A_EN, 32'h7FFF_FFFF);
    tick(2);
    rd(A_CLM, 32'd1, "R3 disabling top ID");
    wr(A_EN, 32'hFFFF_FFFF);
    tick(2);
    wr(A_CLM, 32'd31);
    tick(2);
    rd(A_CLM, 32'd1, "R8 next after top ID");
    wr(A_CLM, 32'd1);
    tick(2);
    rd(A_CLM, 32'd0, "R8 empty after last");
    rd(A_PEND, 32'd0, "R2 pending empty");
    chk({31'd0, irq_o}, 32'd0, "R10 irq idle");

    tick(3);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule